// File: doc/BRIEF.md
# Port Power State Controller

This block follows the power-management state of one bridge port inside a switch. The port is always in exactly one of four states: D0 uninitialized, D0 active, D3hot or D3cold. It moves between them on a fundamental reset, on an indication that software has finished configuring the bridge, on writes to a two-bit power-state control field, on loss of device power, and on the return of power.

The current state is presented as a one-hot vector. The stored power-state field is read back on its own port. Both outputs are registered, so an input sampled at one rising clock edge shows on the outputs just after that edge.

A fundamental reset alone is enough to return the port to D0 uninitialized from any powered state. D3cold is exited only when the fundamental reset arrives together with the power-restored indication. A write of the D0 code while in D3hot lands the port in D0 uninitialized, not D0 active.

Top module: `pwr_state_ctl`

## Requirements
- R1: A low `rst_n`, or an accepted fundamental reset, puts the state at D0 uninitialized and the field at 2'b00 on the next edge. A fundamental reset is accepted in every state except D3cold, where it also needs `pwr_back`.
- R2: In D0 uninitialized, with no accepted reset, `sw_cfg` high moves the port to D0 active.
- R3: `sw_cfg` has no effect in D0 active, D3hot or D3cold.
- R4: In D0 active, a write of 2'b11 moves the port to D3hot and sets the field to 2'b11. A write of 2'b00 keeps the port in D0 active with the field at 2'b00.
- R5: In D3hot, a write of 2'b00 moves the port to D0 uninitialized and sets the field to 2'b00. A write of 2'b11 keeps D3hot.
- R6: In D3hot, `pwr_lost` moves the port to D3cold and the field keeps its value. In every other state `pwr_lost` is ignored.
- R7: D3cold is held unless `fund_rst` and `pwr_back` are both high in the same cycle. Either signal alone has no effect.
- R8: Writes of 2'b01 or 2'b10 are ignored: the state and the field keep their values.
- R9: Writes of any code are ignored in D0 uninitialized and in D3cold.
- R10: An accepted fundamental reset takes priority over every other input in the same cycle.
- R11: `state_oh` is always one-hot, with bit 0 = D0 uninitialized, bit 1 = D0 active, bit 2 = D3hot and bit 3 = D3cold.
- R12: In D3hot, `pwr_lost` takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fund_rst | input | 1 | Fundamental reset pulse |
| pwr_back | input | 1 | Power and clock restored |
| pwr_lost | input | 1 | Device power removed |
| sw_cfg | input | 1 | Software has configured the bridge |
| wr_en | input | 1 | Write strobe for the power-state field |
| wr_code | input | 2 | Write data for the power-state field |
| state_oh | output | 4 | One-hot current state |
| ps_field | output | 2 | Readback of the power-state field |

## Verification
The bench brings the port into each of the four states. From each state it applies every combination of the seven control inputs, then compares the next state and the field against a model computed from the rules.

That sweep covers several corner cases:
- A fundamental reset without `pwr_back` while in D3cold. A design that accepted it would leave D3cold too early.
- A D0 write from D3hot. A design that went to D0 active would skip reinitialization.
- Reserved codes. A design that stored them would corrupt the readback.
- `pwr_lost` together with a write in D3hot. A design with the wrong priority would wake instead of losing power.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  parameter int unsigned NUM_ST = 4;
  parameter int unsigned CODE_W = 2;

  localparam int unsigned ST_D0U = 0;
  localparam int unsigned ST_D0A = 1;
  localparam int unsigned ST_D3H = 2;
  localparam int unsigned ST_D3C = 3;

  typedef logic [NUM_ST-1:0] st_vec_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_D0  = '0;
  localparam code_t CODE_D3H = '1;

  function automatic st_vec_t st_bit(input int unsigned idx);
    st_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic logic code_is_d0(input code_t c);
    return c == CODE_D0;
  endfunction

  function automatic logic code_is_d3(input code_t c);
    return c == CODE_D3H;
  endfunction

  function automatic logic code_valid(input code_t c);
    return code_is_d0(c) || code_is_d3(c);
  endfunction
endpackage

// File: rtl/ps_evt_decode.sv
module ps_evt_decode
  import pwr_state_pkg::*;
(
  input  st_vec_t st,
  input  logic    fund_rst,
  input  logic    pwr_back,
  input  logic    pwr_lost,
  input  logic    sw_cfg,
  input  logic    wr_en,
  input  code_t   wr_code,
  output logic    rst_take,
  output logic    cfg_take,
  output logic    cold_take,
  output logic    wr_d0,
  output logic    wr_d3
);
  logic wr_window;
  logic wr_ok;

  always_comb begin
    // In D3cold the reset counts only together with power restore.
    rst_take  = fund_rst && (!st[ST_D3C] || pwr_back);
    cfg_take  = !rst_take && st[ST_D0U] && sw_cfg;
    cold_take = !rst_take && st[ST_D3H] && pwr_lost;
    wr_window = st[ST_D0A] || st[ST_D3H];
    wr_ok     = wr_en && wr_window && !rst_take && !cold_take
                && code_valid(wr_code);
    wr_d0     = wr_ok && code_is_d0(wr_code);
    wr_d3     = wr_ok && code_is_d3(wr_code);
  end
endmodule

// File: rtl/ps_state_fsm.sv
module ps_state_fsm
  import pwr_state_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rst_take,
  input  logic    cfg_take,
  input  logic    cold_take,
  input  logic    wr_d0,
  input  logic    wr_d3,
  output st_vec_t st_q
);
  st_vec_t st_d;

  always_comb begin
    st_d = st_q;
    if (rst_take) begin
      st_d = st_bit(ST_D0U);
    end else begin
      unique case (1'b1)
        st_q[ST_D0U]: if (cfg_take) st_d = st_bit(ST_D0A);
        st_q[ST_D0A]: if (wr_d3) st_d = st_bit(ST_D3H);
        st_q[ST_D3H]: begin
          if (cold_take)  st_d = st_bit(ST_D3C);
          else if (wr_d0) st_d = st_bit(ST_D0U);
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= st_bit(ST_D0U);
    else        st_q <= st_d;
  end

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_q) == 1);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_take |=> st_q[ST_D0U]);
  p_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take |=> st_q[ST_D0A]);
  p_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_D0A] && wr_d3) |=> st_q[ST_D3H]);
  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_D3H] && wr_d0) |=> st_q[ST_D0U]);
  p_cold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cold_take |=> st_q[ST_D3C]);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_D3C] && !rst_take) |=> st_q[ST_D3C]);
endmodule

// File: rtl/ps_field_reg.sv
module ps_field_reg
  import pwr_state_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rst_take,
  input  logic  wr_d0,
  input  logic  wr_d3,
  output code_t field_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        field_q <= CODE_D0;
    else if (rst_take) field_q <= CODE_D0;
    else if (wr_d0)    field_q <= CODE_D0;
    else if (wr_d3)    field_q <= CODE_D3H;
  end

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_take && !wr_d0 && !wr_d3) |=> $stable(field_q));
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_take |=> field_q == CODE_D0);
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_state_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fund_rst,
  input  logic              pwr_back,
  input  logic              pwr_lost,
  input  logic              sw_cfg,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [NUM_ST-1:0] state_oh,
  output logic [CODE_W-1:0] ps_field
);
  st_vec_t st_q;
  code_t   field_q;
  logic    rst_take, cfg_take, cold_take, wr_d0, wr_d3;

  ps_evt_decode u_dec (
    .st(st_q), .fund_rst(fund_rst), .pwr_back(pwr_back),
    .pwr_lost(pwr_lost), .sw_cfg(sw_cfg), .wr_en(wr_en),
    .wr_code(wr_code), .rst_take(rst_take), .cfg_take(cfg_take),
    .cold_take(cold_take), .wr_d0(wr_d0), .wr_d3(wr_d3)
  );

  ps_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rst_take(rst_take), .cfg_take(cfg_take),
    .cold_take(cold_take), .wr_d0(wr_d0), .wr_d3(wr_d3), .st_q(st_q)
  );

  ps_field_reg u_fld (
    .clk(clk), .rst_n(rst_n), .rst_take(rst_take),
    .wr_d0(wr_d0), .wr_d3(wr_d3), .field_q(field_q)
  );

  assign state_oh = st_q;
  assign ps_field = field_q;

  p_cfg_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_cfg && !st_q[ST_D0U] && !fund_rst && !wr_en && !pwr_lost)
    |=> $stable(state_oh));
  p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !code_valid(wr_code) && !fund_rst && !st_q[ST_D0U])
    |=> $stable(ps_field));
  p_wr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (st_q[ST_D0U] || st_q[ST_D3C]) && !fund_rst)
    |=> $stable(ps_field));
  p_rst_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fund_rst && !st_q[ST_D3C]) |=> (state_oh[ST_D0U] && ps_field == CODE_D0));
  p_lost_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_D3H] && pwr_lost && wr_en && !fund_rst) |=> state_oh[ST_D3C]);
endmodule

// File: tb/pwr_state_ctl_bench.sv
module pwr_state_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fund_rst = 1'b0, pwr_back = 1'b0, pwr_lost = 1'b0;
  logic       sw_cfg = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_code = 2'b00;
  logic [3:0] state_oh;
  logic [1:0] ps_field;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctl u_pwr_state_ctl (
    .clk(clk), .rst_n(rst_n), .fund_rst(fund_rst), .pwr_back(pwr_back),
    .pwr_lost(pwr_lost), .sw_cfg(sw_cfg), .wr_en(wr_en), .wr_code(wr_code),
    .state_oh(state_oh), .ps_field(ps_field)
  );

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    fund_rst = 0; pwr_back = 0; pwr_lost = 0;
    sw_cfg = 0; wr_en = 0; wr_code = 2'b00;
  endtask

  // Reference model: state index 0..3 and field value from the rules.
  task automatic model(input int s, input logic [1:0] f, input logic [6:0] v,
                       output int ns, output logic [1:0] nf,
                       output string tag);
    logic fr, pb, pl, cf, we;
    logic [1:0] wc;
    {fr, pb, pl, cf, we, wc} = v;
    ns = s; nf = f; tag = "R8";
    if (fr && (s != 3 || pb)) begin
      ns = 0; nf = 2'b00; tag = (s == 3) ? "R7" : "R10";
    end else if (s == 0) begin
      tag = we ? "R9" : "R2";
      if (cf) ns = 1;
    end else if (s == 1) begin
      tag = cf ? "R3" : "R4";
      if (we && wc == 2'b11) begin ns = 2; nf = 2'b11; end
      else if (we && wc == 2'b00) nf = 2'b00;
      else if (we) tag = "R8";
    end else if (s == 2) begin
      if (pl) begin ns = 3; tag = we ? "R12" : "R6"; end
      else if (we && wc == 2'b00) begin ns = 0; nf = 2'b00; tag = "R5"; end
      else if (we && wc == 2'b11) tag = "R5";
      else if (we) tag = "R8";
      else tag = cf ? "R3" : "R6";
    end else begin
      tag = fr ? "R7" : (we ? "R9" : "R7");
    end
  endtask

  task automatic goto(input int s);
    clear_in();
    @(negedge clk); fund_rst = 1; pwr_back = 1;
    @(negedge clk); clear_in();
    if (s >= 1) begin sw_cfg = 1; @(negedge clk); clear_in(); end
    if (s >= 2) begin wr_en = 1; wr_code = 2'b11; @(negedge clk); clear_in(); end
    if (s == 3) begin pwr_lost = 1; @(negedge clk); clear_in(); end
    check(s == 0 ? "R1 entry" : s == 1 ? "R2 entry" : s == 2 ? "R4 entry" : "R6 entry",
          {4'h0, state_oh}, {4'h0, 4'(1 << s)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {4'h0, state_oh}, 8'h01);
    check("R1 reset field", {6'h0, ps_field}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 128; v++) begin
        int ns;
        logic [1:0] nf;
        logic [1:0] f0;
        string tag;
        goto(s);
        f0 = (s >= 2) ? 2'b11 : 2'b00;
        model(s, f0, 7'(v), ns, nf, tag);
        {fund_rst, pwr_back, pwr_lost, sw_cfg, wr_en, wr_code} = 7'(v);
        @(negedge clk);
        clear_in();
        check({tag, " state"}, {4'h0, state_oh}, {4'h0, 4'(1 << ns)});
        check({tag, " field"}, {6'h0, ps_field}, {6'h0, nf});
        check("R11 onehot", 8'($countones(state_oh)), 8'd1);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule